// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the programmable feedback divider of a frequency synthesizer. Its clock is the output of an external dual-modulus prescaler. That prescaler divides the oscillator by P or by P+1, as the block's modulus-control line selects. Each output period lasts B cycles of the block's clock. During the first A of those cycles the block asks for P+1, and during the rest it asks for P. The oscillator is therefore divided by N = B·P + A in total. A 6-bit swallow value A, an 11-bit main value B and a prescaler-size bit (P = 32 or 64) are written through a simple load strobe.

A write goes into a shadow copy. That copy is promoted to the active configuration only at the next period boundary, so a period is never cut short. A configuration with B = 0 or B < A is rejected: the block reports it and keeps its outputs low. A power-down input clears the counters and silences the outputs. P must be chosen so that the prescaler output rate stays within what the counter logic can clock: about 165 MHz at 3 V and about 200 MHz at 5 V.

Top module: `pswallow_div`

## Requirements
- R1: Over every output period, the oscillator cycles passed by a prescaler that divides by (64 if pre_sel else 32) plus mod_ctl total exactly B·P + A.
- R2: Within a period of B clock cycles, mod_ctl is 1 (divide by P+1) in the first A cycles and 0 in the remaining B−A cycles.
- R3: div_pulse is 1 for exactly one cycle, the last cycle of each period, and successive pulses are B cycles apart (B = 1 gives a pulse every cycle).
- R4: pre_sel (0 selects 32/33, 1 selects 64/65) shows the P bit of the active configuration, and it changes only when a new configuration is promoted.
- R5: A loaded configuration becomes active at the first period boundary after the load cycle. A load made in the last cycle of a period waits one more full period. When several loads are made before a boundary, the last one wins.
- R6: An active configuration with B = 0 or B < A sets cfg_bad to 1 and holds mod_ctl and div_pulse at 0. A valid load then starts a full period on the cycle after it is written.
- R7: While pwr_dn is 1, mod_ctl and div_pulse are 0 and the counters are cleared. After release, a full period restarts from its beginning, and loads made during power-down are honoured.
- R8: After rst, mod_ctl, div_pulse and pre_sel are 0 and cfg_bad is 1, because no configuration is active yet.
- R9: A = 0 keeps mod_ctl at 0 for the whole period. A = B keeps it at 1 for the whole period. The widest counts (A = 63, B = 2047) divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Holds counters cleared and outputs low |
| cfg_load | input | 1 | Writes cfg_a, cfg_b, cfg_p64 to the shadow copy |
| cfg_a | input | 6 | Swallow count A |
| cfg_b | input | 11 | Main count B |
| cfg_p64 | input | 1 | Prescaler size: 0 = 32/33, 1 = 64/65 |
| mod_ctl | output | 1 | 1 asks the prescaler for P+1 |
| div_pulse | output | 1 | One-cycle pulse ending each period |
| pre_sel | output | 1 | Prescaler size of the active configuration |
| cfg_bad | output | 1 | Active configuration is invalid |

## Verification
A register write and a period reload can land on the same clock edge. The bench provokes this by waiting until div_pulse is seen and then raising cfg_load in that same cycle. At that edge the pending shadow is promoted while the new value is captured into the shadow. A behavioural model predicts that the new value appears only one whole period later, and the bench judges the edge by comparing mod_ctl, div_pulse and pre_sel against that model on every clock. Power-down releases and invalid-to-valid recoveries are timed against reloads in the same way. A modelled prescaler, driven by the block's own outputs, confirms the B·P + A total at every pulse.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int A_W = 6;
  localparam int B_W = 11;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           p64;
  } div_cfg_t;

  // valid when B is nonzero and not smaller than A
  function automatic logic cfg_ok(div_cfg_t c);
    return (c.b != '0) && (B_W'(c.a) <= c.b);
  endfunction
endpackage

// File: rtl/swallow_cfg.sv
module swallow_cfg
  import pswallow_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  div_cfg_t wr_cfg,
  input  logic     boundary,
  output div_cfg_t act_cfg,
  output div_cfg_t nxt_cfg,
  output logic     act_bad
);
  div_cfg_t shd_q;
  logic     pend_q;

  // configuration that governs the period starting at this boundary
  assign nxt_cfg = (boundary && pend_q) ? shd_q : act_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q   <= '0;
      pend_q  <= 1'b0;
      act_cfg <= '0;
      act_bad <= 1'b1;
    end else begin
      if (load) begin
        shd_q  <= wr_cfg;
        pend_q <= 1'b1;
      end else if (boundary && pend_q) begin
        pend_q <= 1'b0;
      end
      if (boundary) begin
        act_cfg <= nxt_cfg;
        act_bad <= !cfg_ok(nxt_cfg);
      end
    end
  end

  // R5: active configuration only moves at a boundary
  a_r5_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(act_cfg));

  // R6: a configuration not flagged bad satisfies B >= A, B > 0
  a_r6_flag_consistent: assert property (@(posedge clk) disable iff (rst)
    !act_bad |-> (act_cfg.b != '0 && B_W'(act_cfg.a) <= act_cfg.b));
endmodule

// File: rtl/swallow_cnt.sv
module swallow_cnt
  import pswallow_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pwr_dn,
  input  div_cfg_t nxt_cfg,
  output logic     boundary,
  output logic     mod_q,
  output logic     pulse_q
);
  logic [B_W-1:0] st_b, nx_b;
  logic [A_W-1:0] st_a, nx_a;

  // idle (st_b == 0) or last cycle of a period (st_b == 1)
  assign boundary = !pwr_dn && (st_b <= B_W'(1));

  always_comb begin
    if (pwr_dn) begin
      nx_b = '0;
      nx_a = '0;
    end else if (boundary) begin
      if (cfg_ok(nxt_cfg)) begin
        nx_b = nxt_cfg.b;
        nx_a = nxt_cfg.a;
      end else begin
        nx_b = '0;
        nx_a = '0;
      end
    end else begin
      nx_b = st_b - B_W'(1);
      nx_a = (st_a != '0) ? st_a - A_W'(1) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_b    <= '0;
      st_a    <= '0;
      mod_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      st_b    <= nx_b;
      st_a    <= nx_a;
      mod_q   <= (nx_a != '0);
      pulse_q <= (nx_b == B_W'(1));
    end
  end

  // R2: swallow cycles never outlast the period
  a_r2_swallow_within_period: assert property (@(posedge clk) disable iff (rst)
    B_W'(st_a) <= st_b);

  // R3: mid-period the main count steps down by one
  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (st_b > B_W'(1) && !pwr_dn) |=> st_b == $past(st_b) - B_W'(1));

  // R7: power-down clears counters and silences outputs
  a_r7_pd_clears: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (st_b == '0 && !mod_q && !pulse_q));
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_dn,
  input  logic           cfg_load,
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  input  logic           cfg_p64,
  output logic           mod_ctl,
  output logic           div_pulse,
  output logic           pre_sel,
  output logic           cfg_bad
);
  div_cfg_t wr_cfg, act_cfg, nxt_cfg;
  logic     boundary;

  assign wr_cfg = '{a: cfg_a, b: cfg_b, p64: cfg_p64};

  swallow_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_load),
    .wr_cfg   (wr_cfg),
    .boundary (boundary),
    .act_cfg  (act_cfg),
    .nxt_cfg  (nxt_cfg),
    .act_bad  (cfg_bad)
  );

  swallow_cnt u_cnt (
    .clk      (clk),
    .rst      (rst),
    .pwr_dn   (pwr_dn),
    .nxt_cfg  (nxt_cfg),
    .boundary (boundary),
    .mod_q    (mod_ctl),
    .pulse_q  (div_pulse)
  );

  assign pre_sel = act_cfg.p64;

  // R6: rejected configuration keeps outputs quiet
  a_r6_bad_silent: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |-> (!div_pulse && !mod_ctl));

  // R4: prescaler size changes only at a period boundary
  a_r4_psel_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (pre_sel != $past(pre_sel)) |-> $past(boundary));
endmodule

// File: tb/pswallow_div_bench.sv
module pswallow_div_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn = 1'b0;
  logic cfg_load = 1'b0;
  logic [5:0] cfg_a = '0;
  logic [10:0] cfg_b = '0;
  logic cfg_p64 = 1'b0;
  logic mod_ctl, div_pulse, pre_sel, cfg_bad;

  int n_chk = 0;
  int n_bad = 0;
  string req = "R8";
  bit done = 1'b0;

  always #10 clk = ~clk;

  pswallow_div u_pswallow_div (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .cfg_load(cfg_load),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_p64(cfg_p64),
    .mod_ctl(mod_ctl), .div_pulse(div_pulse), .pre_sel(pre_sel), .cfg_bad(cfg_bad)
  );

  // behavioural reference
  int sh_a, sh_b, act_a, act_b, m_pos;
  bit sh_p, act_p, m_pend, m_run, m_bad;
  bit exp_mod, exp_pulse;

  always @(posedge clk) begin
    if (rst) begin
      sh_a = 0; sh_b = 0; sh_p = 0; act_a = 0; act_b = 0; act_p = 0;
      m_pend = 0; m_run = 0; m_bad = 1; m_pos = 0;
    end else begin
      if (pwr_dn) m_run = 0;
      else if (!m_run || m_pos == act_b - 1) begin
        if (m_pend) begin
          act_a = sh_a; act_b = sh_b; act_p = sh_p; m_pend = 0;
        end
        m_bad = !(act_b >= 1 && act_b >= act_a);
        m_run = !m_bad;
        m_pos = 0;
      end else m_pos++;
      if (cfg_load) begin
        sh_a = cfg_a; sh_b = cfg_b; sh_p = cfg_p64; m_pend = 1;
      end
    end
    exp_mod   = m_run && (m_pos < act_a);
    exp_pulse = m_run && (m_pos == act_b - 1);
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // R1: behavioural prescaler counting oscillator cycles
  longint vco = 0;

  task automatic step();
    @(negedge clk);
    chk("mod_ctl (R2)", mod_ctl, exp_mod);
    chk("div_pulse (R3)", div_pulse, exp_pulse);
    chk("pre_sel (R4)", pre_sel, act_p);
    chk("cfg_bad (R6)", cfg_bad, m_bad);
    if (!m_run) vco = 0;
    else begin
      vco += (pre_sel ? 64 : 32) + (mod_ctl ? 1 : 0);
      if (div_pulse) begin
        n_chk++;
        if (vco != longint'(act_b) * (act_p ? 64 : 32) + act_a) begin
          n_bad++;
          $display("FAIL R1 total division: actual=%0d expected=%0d", vco,
                   longint'(act_b) * (act_p ? 64 : 32) + act_a);
        end
        vco = 0;
      end
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic load(int a, int b, bit p);
    cfg_a = 6'(a); cfg_b = 11'(b); cfg_p64 = p; cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 3000 && !div_pulse; i++) step();
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL %s watchdog: actual=hung expected=finished", req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    req = "R8";
    run(3);
    rst = 1'b0;
    run(4);
    req = "R2";
    load(3, 7, 0);
    run(30);
    req = "R9";
    load(0, 5, 1);
    run(15);
    load(5, 5, 1);
    run(15);
    load(1, 1, 0);
    run(6);
    load(63, 2047, 1);
    run(4200);
    req = "R5";
    load(2, 9, 0);
    run(12);
    load(4, 6, 1);
    run(2);
    load(1, 3, 0);
    run(20);
    wait_pulse();
    cfg_a = 6'd6; cfg_b = 11'd10; cfg_p64 = 1'b1; cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
    run(30);
    req = "R6";
    load(9, 4, 0);
    run(25);
    load(0, 0, 1);
    run(10);
    load(2, 4, 1);
    run(15);
    req = "R7";
    run(2);
    pwr_dn = 1'b1;
    run(5);
    load(3, 8, 0);
    run(4);
    pwr_dn = 1'b0;
    run(30);
    req = "R8";
    rst = 1'b1;
    run(2);
    rst = 1'b0;
    run(5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule